// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block lets a processor core pull one 32-bit word off a single serial input line. The core raises a receive command for one of two input lines, port A or port B. From then on the block takes one bit per clock from that line and looks for a three-bit sync pattern, low then high then low. It shifts in the next 32 bits as the payload. The whole exchange, pattern and payload together, must fit inside a fixed budget of 64 clocks. If it fits, the core gets the word with the carry-style flag cleared. If it does not, the core gets a zero word with the flag set.

Both lines pass through their own two-flop synchronizer. A single state machine, one header matcher, one shift register and one window counter serve whichever line the command picked. The core sees `busy` while a receive is in progress. It sees a one-clock `done` pulse when the result is ready, and the result stays on the outputs until the next pulse.

The state machine has four states. `ST_IDLE` waits for a command. `ST_HUNT` matches the sync pattern. `ST_DATA` shifts in the payload. `ST_FINISH` is the one-clock result state. The transitions are:
- start: `ST_IDLE` to `ST_HUNT` on an accepted command.
- sync found: `ST_HUNT` to `ST_DATA`.
- hunt expiry: `ST_HUNT` to `ST_FINISH` when the window runs out.
- word complete: `ST_DATA` to `ST_FINISH` on the last payload bit.
- data expiry: `ST_DATA` to `ST_FINISH` when the window runs out.
- release: `ST_FINISH` to `ST_IDLE`.

Top module: `framed_word_rx`

## Requirements
- R1: After reset the block is idle, with `busy`, `done` and `timeout_flag` at 0 and `rx_word` at 0.
- R2: Each line passes through a two-flop synchronizer. A line value present before rising edge e is the bit the receive logic consumes at edge e+2.
- R3: A command is accepted only in idle, and `busy` is 1 from the following cycle. If `cmd_a` and `cmd_b` are both high in the accepting cycle, port A is chosen.
- R4: The sync pattern is the bit sequence 0, 1, 0. With k bits matched (k = 0, 1 or 2), the expected bit is 1 when k = 1 and 0 otherwise. On a mismatch the match count restarts at 1 if the received bit is 0, and at 0 if it is 1. The window counter is not reset by a mismatch.
- R5: The 32 bits right after the pattern form the payload, first bit received ending up in bit 31. On success `rx_word` holds the payload and `timeout_flag` is 0.
- R6: The window is the 64 bits consumed at the 64 clock edges after the accepting edge. A message whose last payload bit is the 64th bit succeeds.
- R7: If the payload is not complete by the 64th bit, `done` is raised with `timeout_flag` at 1 and `rx_word` at 0. This includes the case where the pattern completes on the 64th bit.
- R8: `done` is high for exactly one clock, in the cycle that follows the edge that consumed the final bit or the 64th bit. `busy` is 0 during that cycle.
- R9: A command raised while a receive is in progress is ignored. It neither restarts nor adds a receive.
- R10: Only the selected line is observed. A valid message on the other line has no effect.
- R11: `rx_word` and `timeout_flag` change only in the cycle in which `done` is high, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_a | input | 1 | Start a receive on line A |
| cmd_b | input | 1 | Start a receive on line B |
| line_a | input | 1 | Serial input line A (asynchronous) |
| line_b | input | 1 | Serial input line B (asynchronous) |
| busy | output | 1 | Receive in progress |
| done | output | 1 | One-clock result strobe |
| rx_word | output | 32 | Received word, 0 after a timeout |
| timeout_flag | output | 1 | 1 when the window expired, 0 on success |

## Verification
Two functions can land on the same clock edge: the payload's final bit and the window's 64th bit. Success must win there, and one bit later the receive must expire. This is provoked by padding the stream with 27 and then 28 idle-high bits ahead of the pattern. The `done` cycle, word and flag are judged against a bench model that walks the synchronized bit sequence. A second collision, both commands in one cycle, is judged by checking that port A's word is returned while port B carries a different message.

// File: rtl/framed_word_rx_pkg.sv
package framed_word_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HUNT   = 2'd1,
        ST_DATA   = 2'd2,
        ST_FINISH = 2'd3
    } rx_state_e;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    logic [STAGES-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= {q[STAGES-2:0], d_in};
        end
    end

    assign d_out = q[STAGES-1];

endmodule

// File: rtl/rx_window_ctr.sv
module rx_window_ctr #(
    parameter int WINDOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);

    localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = step && (cnt_q == CW'(WINDOW - 1));

    // the state machine must stop stepping once the final window bit is consumed
    AST_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == CW'(WINDOW - 1)) |=> !step); // R6

endmodule

// File: rtl/framed_word_rx.sv
module framed_word_rx
    import framed_word_rx_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int WINDOW      = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_a,
    input  logic              cmd_b,
    input  logic              line_a,
    input  logic              line_b,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              timeout_flag
);

    localparam int NUM_PORTS = 2;
    localparam int BCW       = $clog2(WORD_W);

    rx_state_e         state_q, state_d;
    logic [NUM_PORTS-1:0] line_vec, sync_vec;
    logic              port_q;
    logic [1:0]        hdr_q;
    logic [BCW-1:0]    bit_cnt_q;
    logic [WORD_W-1:0] shreg_q, word_q;
    logic              flag_q;
    logic              bit_in, accept, win_last, pay_last;

    assign line_vec = {line_b, line_a};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sync
        rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_in  (line_vec[p]),
            .d_out (sync_vec[p])
        );
    end

    assign bit_in   = sync_vec[port_q];
    assign accept   = (state_q == ST_IDLE) && (cmd_a || cmd_b);
    assign pay_last = (state_q == ST_DATA) && (bit_cnt_q == BCW'(WORD_W - 1));

    rx_window_ctr #(.WINDOW(WINDOW)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (busy),
        .last  (win_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_a || cmd_b) state_d = ST_HUNT;
            ST_HUNT: begin
                if (win_last)                           state_d = ST_FINISH;
                else if (hdr_q == 2'd2 && !bit_in)      state_d = ST_DATA;
            end
            ST_DATA:   if (pay_last || win_last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy         = (state_q == ST_HUNT) || (state_q == ST_DATA);
        done         = (state_q == ST_FINISH);
        rx_word      = word_q;
        timeout_flag = flag_q;
    end

    // datapath: header matcher, payload shifter, result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q    <= 1'b0;
            hdr_q     <= 2'd0;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            word_q    <= '0;
            flag_q    <= 1'b0;
        end else begin
            if (accept) begin
                port_q    <= ~cmd_a;
                hdr_q     <= 2'd0;
                bit_cnt_q <= '0;
            end else if (state_q == ST_HUNT) begin
                if (bit_in == (hdr_q == 2'd1)) begin
                    hdr_q <= hdr_q + 2'd1;
                end else begin
                    hdr_q <= bit_in ? 2'd0 : 2'd1;
                end
            end else if (state_q == ST_DATA) begin
                shreg_q   <= {shreg_q[WORD_W-2:0], bit_in};
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end

            if (pay_last) begin
                word_q <= {shreg_q[WORD_W-2:0], bit_in};
                flag_q <= 1'b0;
            end else if (win_last) begin
                word_q <= '0;
                flag_q <= 1'b1;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IDLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout_flag) |-> (rx_word == '0)); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rx_word) && $stable(timeout_flag))); // R11
    AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_a || cmd_b)); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done)); // R9

endmodule

// File: tb/framed_word_rx_tb_top.sv
module framed_word_rx_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] word;
        logic        flag;
        int          at_edge;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_a = 1'b0, cmd_b = 1'b0;
    logic        line_a = 1'b1, line_b = 1'b1;
    logic        busy, done, timeout_flag;
    logic [31:0] rx_word;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   cyc      = 0;
    bit   finished = 1'b0;
    logic prev_done = 1'b0;
    logic [31:0] last_word = '0;
    logic        last_flag = 1'b0;

    exp_t sb[$];
    logic strm[$];
    logic decoy[$];

    framed_word_rx dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_a        (cmd_a),
        .cmd_b        (cmd_b),
        .line_a       (line_a),
        .line_b       (line_b),
        .busy         (busy),
        .done         (done),
        .rx_word      (rx_word),
        .timeout_flag (timeout_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void add_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) strm.push_back(v[i]);
    endfunction

    // protocol model over the synchronized bit sequence
    task automatic model(input logic idle, output logic [31:0] w, output logic fl, output int jend);
        int h = 0;
        int bc = 0;
        bit indata = 0;
        logic [31:0] sh = '0;
        logic b;
        w = '0; fl = 1'b1; jend = 64;
        for (int j = 1; j <= 64; j++) begin
            if (j <= 2) b = idle;
            else if (j - 3 < strm.size()) b = strm[j - 3];
            else b = idle;
            if (!indata) begin
                if (h == 2 && b == 1'b0) indata = 1;
                else if (b == (h == 1)) h++;
                else h = b ? 0 : 1;
            end else begin
                sh = {sh[30:0], b};
                bc++;
                if (bc == 32) begin
                    w = sh; fl = 1'b0; jend = j;
                    return;
                end
            end
        end
    endtask

    task automatic run_msg(input bit use_b, input bit both, input logic idle, input int poke_at);
        logic [31:0] ew;
        logic        ef;
        int          jend, c;
        exp_t        e;
        line_a = idle; line_b = idle;
        repeat (3) @(negedge clk);
        model(idle, ew, ef, jend);
        @(negedge clk);
        cmd_a = !use_b || both;
        cmd_b = use_b || both;
        c = cyc + 1;
        e.word = ew; e.flag = ef; e.at_edge = c + jend;
        sb.push_back(e);
        for (int i = 0; i < 70; i++) begin
            logic sel_b, oth;
            @(negedge clk);
            cmd_a = 1'b0; cmd_b = 1'b0;
            if (i == 0) chk(busy === 1'b1, "R3 busy after command", 32'(busy), 32'd1);
            if (i == poke_at) begin cmd_a = 1'b1; cmd_b = 1'b1; end
            sel_b = use_b && !both;
            oth   = (i < decoy.size()) ? decoy[i] : idle;
            if (sel_b) begin
                line_b = (i < strm.size()) ? strm[i] : idle;
                line_a = oth;
            end else begin
                line_a = (i < strm.size()) ? strm[i] : idle;
                line_b = oth;
            end
        end
        line_a = idle; line_b = idle;
        repeat (2) @(negedge clk);
        chk(sb.size() == 0, "R8 done observed", 32'(sb.size()), 32'd0);
        chk(rx_word === ew, "R11 word held", rx_word, ew);
        chk(timeout_flag === ef, "R11 flag held", 32'(timeout_flag), 32'(ef));
        strm.delete();
    endtask

    // monitor: pops expected results as done pulses appear
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done) begin
                if (prev_done) chk(1'b0, "R8 done longer than one clock", 32'd1, 32'd0);
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(rx_word === e.word, e.flag ? "R7 word on timeout" : "R5 received word", rx_word, e.word);
                    chk(timeout_flag === e.flag, e.flag ? "R7 timeout flag" : "R5 flag clear", 32'(timeout_flag), 32'(e.flag));
                    chk(cyc == e.at_edge, "R2 R6 completion cycle", 32'(cyc), 32'(e.at_edge));
                    chk(busy === 1'b0, "R8 busy low with done", 32'(busy), 32'd0);
                end
                last_word = rx_word;
                last_flag = timeout_flag;
            end
            prev_done = done;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog expired", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // decoy message used on the line that is not selected (R10)
        for (int i = 0; i < 3; i++) decoy.push_back(i == 1);
        for (int i = 31; i >= 0; i--) decoy.push_back(logic'(32'h5A5A_5A5A >> i));

        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 control outputs in reset", {30'd0, busy, done}, 32'd0);
        chk(rx_word === '0 && timeout_flag === 1'b0, "R1 result in reset", rx_word, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy === 1'b0 && rx_word === '0, "R1 idle after reset", rx_word, 32'd0);

        // R5: clean message on port A
        add_bits(32'b010, 3); add_bits(32'hDEAD_BEEF, 32);
        run_msg(1'b0, 1'b0, 1'b1, -1);

        // R4: broken patterns before the real one, port B
        add_bits(32'b0110011011, 10); add_bits(32'b010, 3); add_bits(32'h1357_9BDF, 32);
        run_msg(1'b1, 1'b0, 1'b1, -1);

        // R7: nothing but idle
        run_msg(1'b0, 1'b0, 1'b1, -1);

        // R6: last payload bit is the 64th window bit
        add_bits(32'h07FF_FFFF, 27); add_bits(32'b010, 3); add_bits(32'hA5C3_0F96, 32);
        run_msg(1'b0, 1'b0, 1'b1, -1);

        // R7: one bit too late
        add_bits(32'h0FFF_FFFF, 28); add_bits(32'b010, 3); add_bits(32'hA5C3_0F96, 32);
        run_msg(1'b0, 1'b0, 1'b1, -1);

        // R3: both commands together, port A wins; B carries the decoy
        add_bits(32'b010, 3); add_bits(32'h0000_0001, 32);
        run_msg(1'b0, 1'b1, 1'b0, -1);

        // R9: commands during a receive are ignored
        add_bits(32'b010, 3); add_bits(32'hFFFF_0000, 32);
        run_msg(1'b1, 1'b0, 1'b1, 5);

        // R10: message only on the unselected line
        run_msg(1'b1, 1'b0, 1'b1, -1);

        // R5: MSB first with idle-low line
        add_bits(32'b010, 3); add_bits(32'h8000_0001, 32);
        run_msg(1'b0, 1'b0, 1'b0, -1);

        repeat (5) @(negedge clk);
        chk(rx_word === last_word && timeout_flag === last_flag, "R11 final hold", rx_word, last_word);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule